// File: doc/BRIEF.md
# Parallel Port Enhanced-Cycle Address/Data Sequencer

This block is the host-facing part of a parallel port controller for enhanced peripheral cycles. The host sees a small register bus. The registers are a control register that holds a direction bit, a mode field, a status flag, a timeout limit, and two cycle ports. In the enhanced mode, one host read or write to the address port or to the data port runs exactly one byte transfer with the peripheral. The block asserts the address-select or the data-select line, drives the write strobe and data enable for writes, and waits for the peripheral's ready signal. It then releases the select line and acknowledges the host.

The direction bit can be changed only in a configuration mode. Two modes force it to zero. The other modes keep it. In the enhanced mode the transfer direction comes from the type of host access. A direction bit left high suppresses the write strobe. The resolved direction is always visible on a dedicated pin. A programmable limit bounds the wait for the peripheral. If the limit is reached, the cycle is aborted and a sticky timeout flag is raised.

Register offsets: 0 is control, 1 is status, 2 is mode, 3 is the address cycle port, 4 is the data cycle port, and 5 is the timeout limit. Offsets 6 and 7 read as zero.

Top module: `epp_port_seq`

## Requirements
- R1: After reset: asel_n, dsel_n and wstb_n are high, per_doe is low, pdir is low, the mode is 000, the direction bit is 0, the timeout flag is 0 and the limit is 32.
- R2: Control register bits 7:6 always read as zero. Bits 4:0 take the written value in any mode.
- R3: While the mode field (offset 2, bits 2:0) is 000 or 010, the direction bit (control bit 5) is zero. It reads as zero and pdir is low when idle.
- R4: The direction bit is written only while the mode is 001. In every other mode a write leaves it unchanged. It keeps its value when the mode changes from 001 to 011, 100 or 110, and pdir follows it while idle.
- R5: In mode 100, an access to offset 3 runs a cycle with asel_n low. An access to offset 4 runs a cycle with dsel_n low. The two select lines are never low together.
- R6: During a write cycle, per_doe is high, per_dout equals the written byte and pdir is 0. wstb_n is low during the cycle only if the direction bit is 0.
- R7: During a read cycle, per_doe is low, pdir is 1 and wstb_n is high. The byte on per_din is captured at the edge where the select line is released and is returned on hst_rdata together with hst_ack.
- R8: A cycle completes at the first clock edge where per_wait is high. This takes priority over the timeout on the same edge.
- R9: If per_wait stays low, the cycle aborts once the wait count reaches the limit (offset 5). The abort sets status bit 0, and a read cycle then returns 0xFF. Writing 1 to status bit 0 clears the flag.
- R10: A host access made while a cycle is active is ignored: it produces no acknowledge and changes no register.
- R11: Accesses to offsets 3 and 4 outside mode 100 are acknowledged one cycle later with no peripheral activity. Reads of these offsets then return 0.
- R12: Register accesses are acknowledged one cycle after the access. A register read returns its value on hst_rdata while hst_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_addr | input | 3 | Host register offset |
| hst_rd | input | 1 | Host read request, one cycle |
| hst_wr | input | 1 | Host write request, one cycle |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, valid with hst_ack |
| hst_ack | output | 1 | One-cycle acknowledge |
| per_din | input | 8 | Peripheral data bus input |
| per_dout | output | 8 | Peripheral data bus output |
| per_doe | output | 1 | Peripheral data bus output enable |
| per_wait | input | 1 | Peripheral ready, active high |
| asel_n | output | 1 | Address-select strobe, active low |
| dsel_n | output | 1 | Data-select strobe, active low |
| wstb_n | output | 1 | Write strobe, active low |
| pdir | output | 1 | Resolved port direction, 1 = peripheral to host |

## Verification
The assertions assume the host never raises hst_rd and hst_wr together. They also assume per_wait is low whenever no select line is asserted. The stimulus meets both conditions: each access is a single-cycle pulse of one strobe type, and the peripheral model drops per_wait as soon as it sees both selects high. Cycle lengths, response delays and data are drawn at random. The response delays stay well below the limit or the peripheral never answers, so the expected outcome of every cycle is known in advance.

// File: rtl/epp_port_seq.sv
module epp_port_seq #(
  parameter int TW      = 8,
  parameter int TMO_RST = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   hst_addr,
  input  logic         hst_rd,
  input  logic         hst_wr,
  input  logic [7:0]   hst_wdata,
  output logic [7:0]   hst_rdata,
  output logic         hst_ack,
  input  logic [7:0]   per_din,
  output logic [7:0]   per_dout,
  output logic         per_doe,
  input  logic         per_wait,
  output logic         asel_n,
  output logic         dsel_n,
  output logic         wstb_n,
  output logic         pdir
);
  localparam logic [2:0] A_CTL = 3'd0, A_STS = 3'd1, A_MODE = 3'd2,
                         A_ADR = 3'd3, A_DAT = 3'd4, A_TMO = 3'd5;
  localparam logic [2:0] M_CFG = 3'b001, M_EPP = 3'b100;

  logic [2:0]    mode_q;
  logic [4:0]    ctl_q;
  logic          dir_q, tmo_q, busy_q, cyc_rd_q, cyc_adr_q, ack_q;
  logic [TW-1:0] lim_q, cnt_q;
  logic [7:0]    dout_q, rdata_q, reg_rd;

  wire forced  = (mode_q == 3'b000) || (mode_q == 3'b010);
  wire dir_eff = dir_q & ~forced;
  wire acc     = (hst_rd | hst_wr) & ~busy_q;
  wire is_port = (hst_addr == A_ADR) || (hst_addr == A_DAT);
  wire epp_hit = acc & is_port & (mode_q == M_EPP);

  always_comb begin
    case (hst_addr)
      A_CTL:   reg_rd = {2'b00, dir_eff, ctl_q};
      A_STS:   reg_rd = {7'd0, tmo_q};
      A_MODE:  reg_rd = {5'd0, mode_q};
      A_TMO:   reg_rd = 8'(lim_q);
      default: reg_rd = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; ctl_q <= '0; dir_q <= 1'b0; tmo_q <= 1'b0;
      busy_q <= 1'b0; cyc_rd_q <= 1'b0; cyc_adr_q <= 1'b0; ack_q <= 1'b0;
      lim_q <= TW'(TMO_RST); cnt_q <= '0; dout_q <= '0; rdata_q <= '0;
    end else begin
      ack_q <= 1'b0;
      if (forced) dir_q <= 1'b0;
      if (acc && !epp_hit) begin
        ack_q <= 1'b1;
        if (hst_rd) rdata_q <= reg_rd;
        if (hst_wr) begin
          case (hst_addr)
            A_CTL: begin
              ctl_q <= hst_wdata[4:0];
              if (mode_q == M_CFG) dir_q <= hst_wdata[5];
            end
            A_STS:   if (hst_wdata[0]) tmo_q <= 1'b0;
            A_MODE:  mode_q <= hst_wdata[2:0];
            A_TMO:   lim_q <= hst_wdata[TW-1:0];
            default: ;
          endcase
        end
      end
      if (epp_hit) begin
        busy_q    <= 1'b1;
        cyc_rd_q  <= hst_rd;
        cyc_adr_q <= (hst_addr == A_ADR);
        dout_q    <= hst_wdata;
        cnt_q     <= '0;
      end
      if (busy_q) begin
        if (per_wait) begin
          busy_q <= 1'b0;
          ack_q  <= 1'b1;
          if (cyc_rd_q) rdata_q <= per_din;
        end else if (cnt_q == lim_q) begin
          busy_q <= 1'b0;
          ack_q  <= 1'b1;
          tmo_q  <= 1'b1;
          if (cyc_rd_q) rdata_q <= 8'hFF;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign hst_ack   = ack_q;
  assign hst_rdata = rdata_q;
  assign per_dout  = dout_q;
  assign per_doe   = busy_q & ~cyc_rd_q;
  assign asel_n    = ~(busy_q & cyc_adr_q);
  assign dsel_n    = ~(busy_q & ~cyc_adr_q);
  assign wstb_n    = ~(busy_q & ~cyc_rd_q & ~dir_eff);
  assign pdir      = busy_q ? cyc_rd_q : dir_eff;

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(!asel_n && !dsel_n)); // R5
  AST_DIR_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    forced |=> !dir_q); // R3
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_CFG && !forced) |=> $stable(dir_q)); // R4
  AST_STB_ONLY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !wstb_n |-> (per_doe && !pdir)); // R6
  AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pdir && (!asel_n || !dsel_n)) |-> !per_doe); // R7
  AST_TMO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> $past(busy_q && !per_wait)); // R9
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((!asel_n || !dsel_n) && !per_wait && cnt_q != lim_q) |=> !hst_ack); // R10
endmodule

// File: tb/sim_epp_port_seq.sv
module sim_epp_port_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] hst_addr = '0;
  logic hst_rd = 1'b0, hst_wr = 1'b0;
  logic [7:0] hst_wdata = '0, hst_rdata, per_din = '0, per_dout;
  logic hst_ack, per_doe, per_wait = 1'b0, asel_n, dsel_n, wstb_n, pdir;

  epp_port_seq u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int dly = 0, pcnt = 0;
  bit respond = 1'b0;
  bit saw_a, saw_d, saw_stb, saw_doe, saw_pin, saw_pout;
  logic [7:0] saw_dout;

  always @(negedge clk) begin
    if (!asel_n || !dsel_n) begin
      if (!asel_n) saw_a = 1'b1;
      if (!dsel_n) saw_d = 1'b1;
      if (!wstb_n) saw_stb = 1'b1;
      if (per_doe) begin saw_doe = 1'b1; saw_dout = per_dout; end
      if (pdir) saw_pin = 1'b1; else saw_pout = 1'b1;
      if (respond && pcnt >= dly) per_wait = 1'b1;
      pcnt++;
    end else begin
      per_wait = 1'b0;
      pcnt = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctl(input logic [4:0] c, input bit d);
    return {2'b00, d, c};
  endfunction

  function automatic logic [7:0] exp_read(input bit resp, input logic [7:0] din);
    return resp ? din : 8'hFF;
  endfunction

  task automatic access(input logic [2:0] a, input bit rd, input logic [7:0] d,
                        output logic [7:0] q, output bit acked);
    int n = 0;
    @(negedge clk);
    saw_a = 0; saw_d = 0; saw_stb = 0; saw_doe = 0; saw_pin = 0; saw_pout = 0;
    hst_addr = a; hst_rd = rd; hst_wr = !rd; hst_wdata = d;
    @(negedge clk);
    hst_rd = 1'b0; hst_wr = 1'b0;
    while (!hst_ack && n < 300) begin @(negedge clk); n++; end
    acked = hst_ack;
    q = hst_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] q; bit k;
    access(a, 1'b0, d, q, k);
  endtask

  task automatic rdv(input logic [2:0] a, output logic [7:0] q);
    bit k;
    access(a, 1'b1, 8'h00, q, k);
  endtask

  initial begin
    logic [7:0] q; bit k;
    int n;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 asel_n", asel_n, 1); chk("R1 dsel_n", dsel_n, 1);
    chk("R1 wstb_n", wstb_n, 1); chk("R1 per_doe", per_doe, 0);
    chk("R1 pdir", pdir, 0);
    rdv(3'd2, q); chk("R1 mode", q, 0);
    rdv(3'd0, q); chk("R1 ctl", q, 0);
    rdv(3'd1, q); chk("R1 status", q, 0);
    rdv(3'd5, q); chk("R1 limit", q, 32);

    wr(3'd2, 8'h01); wr(3'd0, 8'hFF);
    rdv(3'd0, q); chk("R2 R12 ctl bits 7:6 zero", q, exp_ctl(5'h1F, 1'b1));
    chk("R4 pdir follows dir in 001", pdir, 1);
    wr(3'd2, 8'h00);
    rdv(3'd0, q); chk("R3 dir forced in 000", q[5], 0);
    chk("R3 pdir low in 000", pdir, 0);
    wr(3'd2, 8'h02); wr(3'd0, 8'h20);
    rdv(3'd0, q); chk("R3 R4 dir write ignored in 010", q, exp_ctl(5'h00, 1'b0));

    foreach (q[i]) begin end
    for (int m = 0; m < 3; m++) begin
      logic [2:0] tgt;
      tgt = (m == 0) ? 3'b011 : (m == 1) ? 3'b110 : 3'b100;
      wr(3'd2, 8'h01); wr(3'd0, 8'h20);
      wr(3'd2, {5'd0, tgt});
      rdv(3'd0, q); chk("R4 dir kept after mode change", q[5], 1);
      chk("R4 pdir kept", pdir, 1);
      wr(3'd0, 8'h0A);
      rdv(3'd0, q); chk("R4 R2 dir not writable outside 001", q, exp_ctl(5'h0A, 1'b1));
    end

    respond = 1'b1; dly = 2;
    access(3'd4, 1'b0, 8'h5A, q, k);
    chk("R6 no strobe with dir high", saw_stb, 0);
    chk("R6 data enable with dir high", saw_doe, 1);
    chk("R5 data select", saw_d, 1);

    wr(3'd2, 8'h01); wr(3'd0, 8'h00); wr(3'd2, 8'h04);
    for (int i = 0; i < 60; i++) begin
      bit rd, isadr;
      logic [7:0] d, din;
      rd = $urandom_range(0, 1); isadr = $urandom_range(0, 1);
      d = 8'($urandom); din = 8'($urandom); per_din = din;
      respond = ($urandom_range(0, 4) != 0); dly = $urandom_range(0, 20);
      access(isadr ? 3'd3 : 3'd4, rd, d, q, k);
      chk("R8 cycle acknowledged", k, 1);
      chk("R5 address select", saw_a, isadr);
      chk("R5 data select", saw_d, !isadr);
      if (rd) begin
        chk("R7 read no strobe", saw_stb, 0);
        chk("R7 read no enable", saw_doe, 0);
        chk("R7 read pdir high", saw_pin && !saw_pout, 1);
        chk("R7 R9 read data", q, exp_read(respond, din));
      end else begin
        chk("R6 write strobe", saw_stb, 1);
        chk("R6 write dout", saw_dout, d);
        chk("R6 write pdir low", saw_pout && !saw_pin, 1);
      end
      rdv(3'd1, q); chk("R9 timeout flag", q[0], !respond);
      if (!respond) begin
        wr(3'd1, 8'h01);
        rdv(3'd1, q); chk("R9 flag cleared", q[0], 0);
      end
    end

    wr(3'd5, 8'h00);
    respond = 1'b1; dly = 0; per_din = 8'hC3;
    access(3'd3, 1'b1, 8'h00, q, k);
    chk("R8 ready wins at limit 0", q, 8'hC3);
    rdv(3'd1, q); chk("R8 no timeout at limit 0", q[0], 0);
    respond = 1'b0;
    access(3'd3, 1'b1, 8'h00, q, k);
    chk("R9 limit 0 abort", q, 8'hFF);
    wr(3'd1, 8'h01); wr(3'd5, 8'd40);

    wr(3'd0, 8'h05);
    respond = 1'b0;
    @(negedge clk);
    hst_addr = 3'd4; hst_wr = 1'b1; hst_wdata = 8'h77;
    @(negedge clk);
    hst_wr = 1'b0;
    repeat (3) @(negedge clk);
    hst_addr = 3'd0; hst_wr = 1'b1; hst_wdata = 8'h1F;
    @(negedge clk);
    hst_wr = 1'b0;
    chk("R10 no ack while busy", hst_ack, 0);
    n = 0;
    while (!hst_ack && n < 300) begin @(negedge clk); n++; end
    rdv(3'd0, q); chk("R10 ctl unchanged", q, exp_ctl(5'h05, 1'b0));
    wr(3'd1, 8'h01);

    wr(3'd2, 8'h03); respond = 1'b1; dly = 0; per_din = 8'h99;
    access(3'd4, 1'b1, 8'h00, q, k);
    chk("R11 ack outside mode", k, 1);
    chk("R11 read zero", q, 0);
    chk("R11 no select", saw_a || saw_d, 0);
    access(3'd3, 1'b0, 8'h11, q, k);
    chk("R11 write no select", saw_a || saw_d || saw_stb, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule